// File: doc/BRIEF.md
# Flash Row Write Buffer

This block collects up to 32 data words bound for a single 128-byte flash row, then commits them to the flash array with one keyed command. Software first sets the row base address. It then writes words into per-slot register offsets and issues the command. A bitmap tracks which slots have been filled, and only those slots are programmed. The other words in the row are never touched.

The flash array and the protection lookup live outside the block and are shared with other sequencers. Before a commit starts, the block presents the row address to the protection logic. A protected row refuses the whole commit and raises an access-violation flag. The array sees one word-program request at a time, held until it acknowledges, so its timing stays abstract.

The register port has a write strobe and a read path that is combinational from the offset. Byte offsets:

| Offset | Register |
|---|---|
| 0x000 | base address |
| 0x004 | command/busy |
| 0x008 | valid bitmap |
| 0x00C | violation status |
| 0x100 + 4*i | slot i |

Top module: `flash_wrbuf`

## Requirements
- R1: After reset, the valid bitmap (0x008), the command register (0x004), the status register (0x00C) and the array request all read 0.
- R2: While idle, a write to offset 0x100 + 4*i stores the word in slot i, where i is offset bits [6:2]. It also sets bit i of the valid bitmap at 0x008, which reads 0 when no slot holds data.
- R3: A write to 0x000 stores the flash byte address with bits [6:0] forced to 0. Reading 0x000 returns that row base.
- R4: A write to 0x004 with 0x5AC3 in bits [31:16] and bit 0 set starts a commit. Bit 0 of 0x004 then reads 1 until the commit is finished.
- R5: A commit programs only the slots whose valid bit is set, one at a time, in ascending slot order. Each goes to address base + 4*i, and every such address stays inside the base row.
- R6: When the commit completes, the valid bitmap reads 0 and bit 0 of 0x004 falls at the same clock edge.
- R7: A command write with a wrong key, or with bit 0 clear, starts nothing and changes no state.
- R8: During a commit, writes to slot offsets and to 0x000 are ignored, and the valid bitmap holds its value.
- R9: If the protection input flags the row when a start command arrives, nothing is programmed. Bit 0 of 0x004 stays 0, the valid bitmap is kept, and bit 0 of 0x00C is set.
- R10: Writing 1 to bit 0 of 0x00C clears the violation flag, and writing 0 leaves it as it is.
- R11: A commit with an empty bitmap reads busy for exactly one cycle and issues no array write.
- R12: An array request holds its address and data steady until the array acknowledges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 9 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| protRowAddr | output | 20 | Row base address under protection check |
| protDeny | input | 1 | Row is protected against programming |
| arrReq | output | 1 | Word program request to the flash array |
| arrAddr | output | 20 | Byte address of the word being programmed |
| arrData | output | 32 | Word being programmed |
| arrAck | input | 1 | Array has accepted the current word |

## Verification
The commit is tried with six slot masks, and each one separates a different fault.

- A full row shows whether any slot is dropped.
- A lone slot 0 or a lone slot 31 exposes errors at the ends of the slot index.
- An alternating mask and a mask with only the two end slots set catch a scan that programs unfilled slots or programs out of order.
- An empty mask shows whether a commit with no work still ends cleanly.

After each commit, the bench compares every word of the target row with the erased value or the written value. This tells an unwanted write apart from a missing one. Directed cases with wrong keys, a locked row and writes made during a commit separate commands that are rejected from state that was corrupted.

// File: rtl/fwb_pkg.sv
package fwb_pkg;

  typedef struct packed {
    logic baseWe;
    logic slotWe;
    logic validClr;
    logic violSet;
    logic violClr;
  } fwbStrobe_t;

  localparam int OFS_BASE  = 'h000;
  localparam int OFS_CMD   = 'h004;
  localparam int OFS_VALID = 'h008;
  localparam int OFS_STAT  = 'h00C;
  localparam int OFS_SLOT  = 'h100;

endpackage

// File: rtl/fwb_ctrl.sv
module fwb_ctrl
  import fwb_pkg::*;
#(
  parameter int WORDS = 32,
  parameter int REG_AW = 9,
  parameter int DATA_W = 32,
  parameter logic [15:0] KEY = 16'h5AC3,
  localparam int SLOT_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [WORDS-1:0]  validMap,
  input  logic              protDeny,
  input  logic              arrAck,
  output fwbStrobe_t        stb,
  output logic              busy,
  output logic              arrReq,
  output logic [SLOT_W-1:0] curSlot
);

  localparam int TAG_W = REG_AW - SLOT_W - 2;
  localparam logic [TAG_W-1:0] SLOT_TAG = TAG_W'(OFS_SLOT >> (SLOT_W + 2));

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t          state;
  logic [WORDS-1:0] pending;
  logic hitBase, hitCmd, hitStat, hitSlot, keyOk, startReq;

  always_comb begin
    hitBase  = regWe && (regAddr == REG_AW'(OFS_BASE));
    hitCmd   = regWe && (regAddr == REG_AW'(OFS_CMD));
    hitStat  = regWe && (regAddr == REG_AW'(OFS_STAT));
    hitSlot  = regWe && (regAddr[REG_AW-1:SLOT_W+2] == SLOT_TAG) && (regAddr[1:0] == 2'b00);
    keyOk    = (regWdata[31:16] == KEY) && regWdata[0];
    startReq = hitCmd && keyOk && (state == ST_IDLE);
  end

  // lowest pending slot goes first
  always_comb begin
    curSlot = '0;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (pending[i]) curSlot = SLOT_W'(i);
    end
  end

  assign busy   = (state == ST_RUN);
  assign arrReq = busy && (pending != '0);

  always_comb begin
    stb          = '0;
    stb.baseWe   = hitBase && !busy;
    stb.slotWe   = hitSlot && !busy;
    stb.violSet  = startReq && protDeny;
    stb.violClr  = hitStat && regWdata[0];
    stb.validClr = busy && (pending == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startReq && !protDeny) begin
            state   <= ST_RUN;
            pending <= validMap;
          end
        end
        ST_RUN: begin
          if (pending == '0) begin
            state <= ST_IDLE;
          end else if (arrAck) begin
            pending[curSlot] <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R12: a request waits, unchanged, for its acknowledge
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (arrReq && !arrAck) |=> (arrReq && $stable(curSlot)));

  // R9: a refused start leaves the sequencer idle
  assert_refuse_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && protDeny) |=> !busy);

endmodule

// File: rtl/fwb_datapath.sv
module fwb_datapath
  import fwb_pkg::*;
#(
  parameter int WORDS = 32,
  parameter int REG_AW = 9,
  parameter int DATA_W = 32,
  parameter int FADDR_W = 20,
  localparam int SLOT_W = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  fwbStrobe_t         stb,
  input  logic               busy,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic [SLOT_W-1:0]  curSlot,
  output logic [DATA_W-1:0]  regRdata,
  output logic [WORDS-1:0]   validMap,
  output logic [FADDR_W-1:0] rowAddr,
  output logic [FADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0]  arrData
);

  localparam int ROW_W = FADDR_W - SLOT_W - 2;
  localparam int TAG_W = REG_AW - SLOT_W - 2;
  localparam logic [TAG_W-1:0] SLOT_TAG = TAG_W'(OFS_SLOT >> (SLOT_W + 2));

  logic [ROW_W-1:0]               baseRow;
  logic                           violFlag;
  logic [WORDS-1:0][DATA_W-1:0]   slotFlat;
  logic [SLOT_W-1:0]              slotIdx;

  assign slotIdx = regAddr[SLOT_W+1:2];

  for (genvar g = 0; g < WORDS; g++) begin : gSlot
    logic [DATA_W-1:0] word;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) word <= '0;
      else if (stb.slotWe && (slotIdx == SLOT_W'(g))) word <= regWdata;
    end
    assign slotFlat[g] = word;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validMap <= '0;
      baseRow  <= '0;
      violFlag <= 1'b0;
    end else begin
      if (stb.validClr) validMap <= '0;
      else if (stb.slotWe) validMap[slotIdx] <= 1'b1;
      if (stb.baseWe) baseRow <= regWdata[FADDR_W-1:SLOT_W+2];
      if (stb.violSet) violFlag <= 1'b1;
      else if (stb.violClr) violFlag <= 1'b0;
    end
  end

  assign rowAddr = {baseRow, (SLOT_W + 2)'(0)};
  assign arrAddr = {baseRow, curSlot, 2'b00};
  assign arrData = slotFlat[curSlot];

  always_comb begin
    regRdata = '0;
    if (regAddr == REG_AW'(OFS_BASE)) regRdata = DATA_W'(rowAddr);
    else if (regAddr == REG_AW'(OFS_CMD)) regRdata = DATA_W'(busy);
    else if (regAddr == REG_AW'(OFS_VALID)) regRdata = DATA_W'(validMap);
    else if (regAddr == REG_AW'(OFS_STAT)) regRdata = DATA_W'(violFlag);
    else if (regAddr[REG_AW-1:SLOT_W+2] == SLOT_TAG) regRdata = slotFlat[slotIdx];
  end

  // R10: the flag drops only on a clear strobe
  assert_viol_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(violFlag) && !$past(stb.violClr)) |-> violFlag);

endmodule

// File: rtl/flash_wrbuf.sv
module flash_wrbuf
  import fwb_pkg::*;
#(
  parameter int WORDS = 32,
  parameter int REG_AW = 9,
  parameter int DATA_W = 32,
  parameter int FADDR_W = 20,
  parameter logic [15:0] KEY = 16'h5AC3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic [FADDR_W-1:0] protRowAddr,
  input  logic               protDeny,
  output logic               arrReq,
  output logic [FADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0]  arrData,
  input  logic               arrAck
);

  localparam int SLOT_W = $clog2(WORDS);

  fwbStrobe_t        stb;
  logic              busy;
  logic [WORDS-1:0]  validMap;
  logic [SLOT_W-1:0] curSlot;

  fwb_ctrl #(.WORDS(WORDS), .REG_AW(REG_AW), .DATA_W(DATA_W), .KEY(KEY)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .validMap(validMap), .protDeny(protDeny), .arrAck(arrAck),
    .stb(stb), .busy(busy), .arrReq(arrReq), .curSlot(curSlot)
  );

  fwb_datapath #(.WORDS(WORDS), .REG_AW(REG_AW), .DATA_W(DATA_W), .FADDR_W(FADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .regAddr(regAddr), .regWdata(regWdata),
    .curSlot(curSlot), .regRdata(regRdata), .validMap(validMap), .rowAddr(protRowAddr),
    .arrAddr(arrAddr), .arrData(arrData)
  );

  // R5: every programmed word sits in a filled slot of the base row
  assert_valid_slot_R5: assert property (@(posedge clk) disable iff (!rstN)
    arrReq |-> (validMap[arrAddr[SLOT_W+1:2]] &&
                arrAddr[FADDR_W-1:SLOT_W+2] == protRowAddr[FADDR_W-1:SLOT_W+2]));

  // R6: the bitmap is empty once busy falls
  assert_clear_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (validMap == '0));

  // R8: the bitmap is frozen while a commit runs
  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(validMap));

endmodule

// File: tb/flash_wrbuf_tb.sv
`timescale 1ns/1ps
module flash_wrbuf_tb;

  localparam logic [15:0] KEY = 16'h5AC3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [8:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [19:0] protRowAddr;
  logic        protDeny;
  logic        arrReq;
  logic [19:0] arrAddr;
  logic [31:0] arrData;
  logic        arrAck;

  int checks = 0;
  int errors = 0;
  int lockRow = -1;

  always #4 clk = ~clk;

  flash_wrbuf u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .protRowAddr(protRowAddr), .protDeny(protDeny),
    .arrReq(arrReq), .arrAddr(arrAddr), .arrData(arrData), .arrAck(arrAck)
  );

  assign protDeny = (lockRow >= 0) && (int'(protRowAddr[19:7]) == lockRow);

  // flash array model: 8 rows, acknowledges after a short wait
  logic [31:0] mem [256];
  logic [19:0] logA [256];
  int          wrCount;
  logic [1:0]  waitC;
  logic        ackR;
  assign arrAck = ackR;

  always @(posedge clk) begin
    if (!rstN) begin
      ackR <= 1'b0;
      waitC <= '0;
      wrCount <= 0;
      for (int i = 0; i < 256; i++) mem[i] <= 32'hFFFF_FFFF;
    end else if (arrReq && !ackR) begin
      if (waitC == 2'd2) begin
        ackR <= 1'b1;
        waitC <= '0;
        mem[arrAddr[9:2]] <= arrData;
        logA[wrCount[7:0]] <= arrAddr;
        wrCount <= wrCount + 1;
      end else begin
        waitC <= waitC + 2'd1;
      end
    end else begin
      ackR <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic waitIdle(output int cyc);
    logic [31:0] r;
    cyc = 0;
    rd(9'h004, r);
    while (r[0] && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      rd(9'h004, r);
    end
  endtask

  function automatic logic [31:0] dval(input int v, input int i);
    return 32'hC0DE_0000 | 32'(v << 8) | 32'(i);
  endfunction

  localparam logic [34:0] VEC [6] = '{
    {3'd0, 32'hFFFF_FFFF},
    {3'd1, 32'h0000_0001},
    {3'd2, 32'h8000_0000},
    {3'd3, 32'h5555_5555},
    {3'd4, 32'h8000_0001},
    {3'd7, 32'h0000_0000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %h expected %h", 32'h0, 32'h1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int snap, cyc, bad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(9'h008, r); chk(r == 0, "R1 valid", r, 0);
    rd(9'h004, r); chk(r == 0, "R1 cmd", r, 0);
    rd(9'h00C, r); chk(r == 0, "R1 stat", r, 0);
    chk(arrReq == 1'b0, "R1 req", 32'(arrReq), 0);

    for (int v = 0; v < 6; v++) begin
      logic [2:0]  row;
      logic [31:0] mask;
      {row, mask} = VEC[v];
      wr(9'h000, 32'(row) * 128 + 32'h44);
      rd(9'h000, r); chk(r == 32'(row) * 128, "R3 base", r, 32'(row) * 128);
      for (int i = 0; i < 32; i++) if (mask[i]) wr(9'h100 + 9'(4 * i), dval(v, i));
      rd(9'h008, r); chk(r == mask, "R2 valid", r, mask);
      snap = wrCount;
      wr(9'h004, {KEY, 16'h0001});
      rd(9'h004, r); chk(r[0] == 1'b1, "R4 busy", r, 1);
      waitIdle(cyc);
      if (mask == 0) chk(cyc == 1, "R11 one cycle", 32'(cyc), 1);
      rd(9'h008, r); chk(r == 0, "R6 cleared", r, 0);
      chk(wrCount - snap == $countones(mask), (mask == 0) ? "R11 writes" : "R5 writes",
          32'(wrCount - snap), 32'($countones(mask)));
      bad = 0;
      for (int i = 0; i < 32; i++)
        if (mem[int'(row) * 32 + i] != (mask[i] ? dval(v, i) : 32'hFFFF_FFFF)) bad++;
      chk(bad == 0, "R5 row content", 32'(bad), 0);
      bad = 0;
      for (int k = snap + 1; k < wrCount; k++) if (logA[k] <= logA[k - 1]) bad++;
      chk(bad == 0, "R5 order", 32'(bad), 0);
    end

    // R7 wrong key and missing start bit
    wr(9'h000, 32'(5 * 128));
    wr(9'h100, 32'h1111_0000);
    wr(9'h104, 32'h1111_0001);
    snap = wrCount;
    wr(9'h004, 32'h1234_0001);
    rd(9'h004, r); chk(r == 0, "R7 bad key", r, 0);
    wr(9'h004, {KEY, 16'h0000});
    rd(9'h004, r); chk(r == 0, "R7 no start bit", r, 0);
    repeat (10) @(negedge clk);
    chk(wrCount == snap, "R7 no writes", 32'(wrCount - snap), 0);
    rd(9'h008, r); chk(r == 32'h3, "R7 valid kept", r, 3);

    // R9 protected row
    lockRow = 5;
    wr(9'h004, {KEY, 16'h0001});
    rd(9'h004, r); chk(r == 0, "R9 not busy", r, 0);
    rd(9'h00C, r); chk(r == 1, "R9 violation", r, 1);
    rd(9'h008, r); chk(r == 32'h3, "R9 valid kept", r, 3);
    repeat (10) @(negedge clk);
    chk(wrCount == snap, "R9 no writes", 32'(wrCount - snap), 0);

    // R10 write-one-to-clear
    wr(9'h00C, 32'h0);
    rd(9'h00C, r); chk(r == 1, "R10 zero keeps", r, 1);
    wr(9'h00C, 32'h1);
    rd(9'h00C, r); chk(r == 0, "R10 cleared", r, 0);

    lockRow = -1;
    wr(9'h004, {KEY, 16'h0001});
    waitIdle(cyc);
    chk(mem[160] == 32'h1111_0000 && mem[161] == 32'h1111_0001 && mem[162] == 32'hFFFF_FFFF,
        "R9 unlocked commit", mem[161], 32'h1111_0001);

    // R8 writes during a commit
    wr(9'h000, 32'(6 * 128));
    for (int i = 0; i < 8; i++) wr(9'h100 + 9'(4 * i), 32'h6600_0000 | 32'(i));
    wr(9'h004, {KEY, 16'h0001});
    wr(9'h108, 32'hDEAD_0002);
    wr(9'h128, 32'hDEAD_000A);
    wr(9'h000, 32'(1 * 128));
    rd(9'h008, r); chk(r == 32'hFF, "R8 valid frozen", r, 32'hFF);
    waitIdle(cyc);
    chk(mem[194] == 32'h6600_0002, "R8 slot data kept", mem[194], 32'h6600_0002);
    chk(mem[202] == 32'hFFFF_FFFF, "R8 no extra slot", mem[202], 32'hFFFF_FFFF);
    rd(9'h000, r); chk(r == 32'(6 * 128), "R8 base kept", r, 32'(6 * 128));
    rd(9'h008, r); chk(r == 0, "R6 cleared after R8", r, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule